// File: doc/BRIEF.md
# Boot Configuration Word Fetcher with External-Boot Lock

After reset is released, this block reads a 32-bit start-up configuration word one byte at a time over a small request/acknowledge bus. It holds the word in a control register and raises a done flag. The system keeps the processor in reset until that flag goes high. Two static test-mode pins choose where the word comes from: internal flash, the internal special-function ROM, or an external multi-function port.

External boot is guarded by a lock flag. Power-on reset forces the flag to 1. A warm reset leaves it as it is. Only a software write can clear it. So the external port can be used only when software has cleared the flag and a warm reset has followed. If external boot is requested while the flag is set, no bus read takes place. A fixed default word is loaded instead, and a sticky status bit records that boot was refused. A build parameter selects a mask-ROM variant. In that variant the flag can still be written and read, but it never blocks the external port.

Top module: `cfgword_boot`

## Requirements
- R1: With `test2_i`=1 the word is read from the special-function ROM (`rd_src_o`=1). With both test pins at 0 it is read from internal flash (`rd_src_o`=0). In both cases the lock flag has no effect.
- R2: With `test_i`=1 and `test2_i`=0 the word is read from the external port (`rd_src_o`=2), but only when `lock_o` is 0 at reset release.
- R3: A fetch makes exactly four reads at byte addresses 0x20, 0x21, 0x22 and 0x23, in that order. Each request holds its address and source steady until `rd_ack_i` is seen.
- R4: The bytes are assembled little-endian. Address 0x20 supplies bits 7:0 and address 0x23 supplies bits 31:24.
- R5: `done_o` is low until the last byte has been acknowledged and the control register has been written. It then stays high until the next reset, and no request is made while it is high.
- R6: Power-on reset (`por_n_i` low) sets `lock_o` to 1, and this takes precedence over a software write in the same cycle. A warm reset leaves `lock_o` unchanged.
- R7: A write on `lock_wr_i` stores `lock_wdata_i` in the lock flag only while `done_o` is high. Writes made during reset or during the fetch are ignored.
- R8: If external boot is requested while locked, no read is issued and the control register is loaded with 0x00007F5F. `blocked_o` is then set, and it stays set across warm resets until the next power-on reset.
- R9: With `MASK_ROM`=1 the lock flag never blocks external boot, and `blocked_o` stays 0.
- R10: While reset is held, `done_o`=0, `rd_req_o`=0 and `ctrl_word_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_n_i | input | 1 | Asynchronous active-low warm reset |
| por_n_i | input | 1 | Asynchronous active-low power-on reset indication; also resets the block |
| test_i | input | 1 | Primary test-mode pin (static) |
| test2_i | input | 1 | Secondary test-mode pin (static) |
| rd_req_o | output | 1 | Byte read request |
| rd_src_o | output | 2 | Selected source: 0 flash, 1 special-function ROM, 2 external port |
| rd_addr_o | output | ADDR_W | Byte address of the request |
| rd_ack_i | input | 1 | Read acknowledge; data valid in the same cycle |
| rd_data_i | input | 8 | Read data byte |
| lock_wr_i | input | 1 | Lock flag write strobe |
| lock_wdata_i | input | 1 | Lock flag write value |
| lock_o | output | 1 | Current lock flag |
| blocked_o | output | 1 | Sticky: external boot was refused |
| ctrl_word_o | output | 8*WORD_BYTES | Control register |
| done_o | output | 1 | Configuration loaded; processor may start |

## Verification
Two events can land in the same cycle: a power-on reset and a software write that clears the lock flag. The bench drives both together and expects the flag to read 1, and the sticky refusal bit to be cleared by that same power-on reset. A second collision is a software clear presented while reset is still held, which is just before the fetch decision. The bench holds the write through the reset window. It then checks that the flag still reads 1 and that an external-boot request is refused with the default word and no bus reads.

// File: rtl/cfgword_pkg.sv
package cfgword_pkg;

  typedef enum logic [1:0] {
    SRC_FLASH = 2'd0,
    SRC_SFROM = 2'd1,
    SRC_EXT   = 2'd2
  } boot_src_e;

  typedef enum logic [1:0] {
    ST_DECIDE = 2'd0,
    ST_FETCH  = 2'd1,
    ST_DONE   = 2'd2
  } fetch_st_e;

endpackage

// File: rtl/cfgword_rstsync.sv
module cfgword_rstsync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic arst_n_i,
  output logic srst_n_o
);

  logic [STAGES-1:0] chain_q;

  // assert asynchronously, release after STAGES rising edges
  always_ff @(posedge clk_i or negedge arst_n_i) begin
    if (!arst_n_i) chain_q <= '0;
    else           chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign srst_n_o = chain_q[STAGES-1];

endmodule

// File: rtl/cfgword_srcsel.sv
module cfgword_srcsel
  import cfgword_pkg::*;
#(
  parameter bit MASK_ROM = 1'b0
) (
  input  logic      test_i,
  input  logic      test2_i,
  input  logic      locked_i,
  output boot_src_e src_o,
  output logic      block_o
);

  always_comb begin
    block_o = 1'b0;
    if (test2_i) begin
      src_o = SRC_SFROM;
    end else if (test_i) begin
      src_o   = SRC_EXT;
      block_o = (MASK_ROM == 1'b0) && locked_i;
    end else begin
      src_o = SRC_FLASH;
    end
  end

endmodule

// File: rtl/cfgword_lock.sv
module cfgword_lock (
  input  logic clk_i,
  input  logic por_n_i,
  input  logic wr_en_i,
  input  logic wr_data_i,
  input  logic wr_ok_i,
  input  logic block_set_i,
  output logic lock_o,
  output logic blocked_o
);

  logic lock_q, lock_d;
  logic blk_q, blk_d;

  always_comb begin
    lock_d = lock_q;
    if (wr_en_i && wr_ok_i) lock_d = wr_data_i;
    blk_d = blk_q | block_set_i;
  end

  // only the power-on domain touches these; warm reset leaves them alone
  always_ff @(posedge clk_i or negedge por_n_i) begin
    if (!por_n_i) begin
      lock_q <= 1'b1;
      blk_q  <= 1'b0;
    end else begin
      lock_q <= lock_d;
      blk_q  <= blk_d;
    end
  end

  assign lock_o    = lock_q;
  assign blocked_o = blk_q;

endmodule

// File: rtl/cfgword_fetch.sv
module cfgword_fetch
  import cfgword_pkg::*;
#(
  parameter int                ADDR_W       = 8,
  parameter int                WORD_BYTES   = 4,
  parameter logic [ADDR_W-1:0] BASE_ADDR    = 'h20,
  parameter logic [8*WORD_BYTES-1:0] DEFAULT_WORD = 'h7F5F
) (
  input  logic                      clk_i,
  input  logic                      srst_n_i,
  input  boot_src_e                 sel_src_i,
  input  logic                      sel_block_i,
  output logic                      req_o,
  output boot_src_e                 src_o,
  output logic [ADDR_W-1:0]         addr_o,
  input  logic                      ack_i,
  input  logic [7:0]                data_i,
  output logic [8*WORD_BYTES-1:0]   word_o,
  output logic                      done_o,
  output logic                      block_set_o
);

  localparam int WORD_W = 8 * WORD_BYTES;
  localparam int IDX_W  = (WORD_BYTES > 1) ? $clog2(WORD_BYTES) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(WORD_BYTES - 1);

  fetch_st_e         state_q, state_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  boot_src_e         src_q, src_d;
  logic [WORD_W-1:0] word_q, word_d;
  logic [WORD_W-1:0] acc_w;

  // one byte lane per configuration byte, each with its own capture enable
  for (genvar g = 0; g < WORD_BYTES; g++) begin : g_lane
    logic       lane_en;
    logic [7:0] lane_q;
    assign lane_en = (state_q == ST_FETCH) && ack_i && (idx_q == IDX_W'(g));
    always_ff @(posedge clk_i or negedge srst_n_i) begin
      if (!srst_n_i)    lane_q <= '0;
      else if (lane_en) lane_q <= data_i;
    end
    assign acc_w[g*8 +: 8] = lane_q;
  end

  always_comb begin
    state_d     = state_q;
    idx_d       = idx_q;
    src_d       = src_q;
    word_d      = word_q;
    block_set_o = 1'b0;
    req_o       = 1'b0;
    unique case (state_q)
      ST_DECIDE: begin
        if (sel_block_i) begin
          word_d      = DEFAULT_WORD;
          block_set_o = 1'b1;
          state_d     = ST_DONE;
        end else begin
          src_d   = sel_src_i;
          idx_d   = '0;
          state_d = ST_FETCH;
        end
      end
      ST_FETCH: begin
        req_o = 1'b1;
        if (ack_i) begin
          if (idx_q == LAST_IDX) begin
            word_d              = acc_w;
            word_d[WORD_W-1 -: 8] = data_i;
            state_d             = ST_DONE;
          end else begin
            idx_d = idx_q + 1'b1;
          end
        end
      end
      ST_DONE: begin
        state_d = ST_DONE;
      end
      default: state_d = ST_DECIDE;
    endcase
  end

  always_ff @(posedge clk_i or negedge srst_n_i) begin
    if (!srst_n_i) begin
      state_q <= ST_DECIDE;
      idx_q   <= '0;
      src_q   <= SRC_FLASH;
      word_q  <= '0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      src_q   <= src_d;
      word_q  <= word_d;
    end
  end

  assign src_o  = src_q;
  assign addr_o = BASE_ADDR + ADDR_W'(idx_q);
  assign word_o = word_q;
  assign done_o = (state_q == ST_DONE);

endmodule

// File: rtl/cfgword_boot.sv
module cfgword_boot
  import cfgword_pkg::*;
#(
  parameter int                      ADDR_W       = 8,
  parameter int                      WORD_BYTES   = 4,
  parameter logic [ADDR_W-1:0]       BASE_ADDR    = 'h20,
  parameter logic [8*WORD_BYTES-1:0] DEFAULT_WORD = 'h7F5F,
  parameter bit                      MASK_ROM     = 1'b0,
  parameter int                      SYNC_STAGES  = 2
) (
  input  logic                    clk_i,
  input  logic                    rst_n_i,
  input  logic                    por_n_i,
  input  logic                    test_i,
  input  logic                    test2_i,
  output logic                    rd_req_o,
  output logic [1:0]              rd_src_o,
  output logic [ADDR_W-1:0]       rd_addr_o,
  input  logic                    rd_ack_i,
  input  logic [7:0]              rd_data_i,
  input  logic                    lock_wr_i,
  input  logic                    lock_wdata_i,
  output logic                    lock_o,
  output logic                    blocked_o,
  output logic [8*WORD_BYTES-1:0] ctrl_word_o,
  output logic                    done_o
);

  logic      any_rst_n;
  logic      srst_n;
  logic      por_sync_n;
  boot_src_e sel_src;
  logic      sel_block;
  boot_src_e cur_src;
  logic      block_set;

  // a power-on reset is also a system reset
  assign any_rst_n = rst_n_i & por_n_i;

  cfgword_rstsync #(.STAGES(SYNC_STAGES)) u_sync_sys (
    .clk_i    (clk_i),
    .arst_n_i (any_rst_n),
    .srst_n_o (srst_n)
  );

  cfgword_rstsync #(.STAGES(SYNC_STAGES)) u_sync_por (
    .clk_i    (clk_i),
    .arst_n_i (por_n_i),
    .srst_n_o (por_sync_n)
  );

  cfgword_lock u_lock (
    .clk_i       (clk_i),
    .por_n_i     (por_sync_n),
    .wr_en_i     (lock_wr_i),
    .wr_data_i   (lock_wdata_i),
    .wr_ok_i     (done_o),
    .block_set_i (block_set),
    .lock_o      (lock_o),
    .blocked_o   (blocked_o)
  );

  cfgword_srcsel #(.MASK_ROM(MASK_ROM)) u_sel (
    .test_i   (test_i),
    .test2_i  (test2_i),
    .locked_i (lock_o),
    .src_o    (sel_src),
    .block_o  (sel_block)
  );

  cfgword_fetch #(
    .ADDR_W       (ADDR_W),
    .WORD_BYTES   (WORD_BYTES),
    .BASE_ADDR    (BASE_ADDR),
    .DEFAULT_WORD (DEFAULT_WORD)
  ) u_fetch (
    .clk_i       (clk_i),
    .srst_n_i    (srst_n),
    .sel_src_i   (sel_src),
    .sel_block_i (sel_block),
    .req_o       (rd_req_o),
    .src_o       (cur_src),
    .addr_o      (rd_addr_o),
    .ack_i       (rd_ack_i),
    .data_i      (rd_data_i),
    .word_o      (ctrl_word_o),
    .done_o      (done_o),
    .block_set_o (block_set)
  );

  assign rd_src_o = cur_src;

endmodule

// File: rtl/cfgword_checker.sv
module cfgword_checker #(
  parameter int                ADDR_W     = 8,
  parameter int                WORD_BYTES = 4,
  parameter logic [ADDR_W-1:0] BASE_ADDR  = 'h20,
  parameter bit                MASK_ROM   = 1'b0
) (
  input logic              clk_i,
  input logic              rst_n_i,
  input logic              por_n_i,
  input logic              test2_i,
  input logic              rd_req_o,
  input logic [1:0]        rd_src_o,
  input logic [ADDR_W-1:0] rd_addr_o,
  input logic              rd_ack_i,
  input logic              lock_wr_i,
  input logic              lock_wdata_i,
  input logic              lock_o,
  input logic              blocked_o,
  input logic              done_o
);

  AST_REQ_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_n_i || !por_n_i)
    (rd_req_o && !rd_ack_i) |=> (rd_req_o && $stable(rd_addr_o) && $stable(rd_src_o))); // R3

  AST_ADDR_IN_WINDOW: assert property (@(posedge clk_i) disable iff (!rst_n_i || !por_n_i)
    rd_req_o |-> ((rd_addr_o >= BASE_ADDR) && (rd_addr_o < BASE_ADDR + ADDR_W'(WORD_BYTES)))); // R3

  AST_SFROM_ON_TEST2: assert property (@(posedge clk_i) disable iff (!rst_n_i || !por_n_i)
    (rd_req_o && test2_i) |-> (rd_src_o == 2'd1)); // R1

  AST_EXT_NEEDS_UNLOCK: assert property (@(posedge clk_i) disable iff (!rst_n_i || !por_n_i)
    (rd_req_o && (rd_src_o == 2'd2)) |-> (MASK_ROM || !lock_o)); // R2

  AST_NO_REQ_AFTER_DONE: assert property (@(posedge clk_i) disable iff (!rst_n_i || !por_n_i)
    done_o |-> !rd_req_o); // R5

  AST_DONE_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_n_i || !por_n_i)
    done_o |=> done_o); // R5

  AST_LOCK_CLEAR_BY_SW: assert property (@(posedge clk_i) disable iff (!por_n_i)
    $fell(lock_o) |-> $past(lock_wr_i && !lock_wdata_i && done_o)); // R7

  AST_BLOCKED_STICKY: assert property (@(posedge clk_i) disable iff (!por_n_i)
    blocked_o |=> blocked_o); // R8

  AST_MASKROM_NEVER_BLOCKS: assert property (@(posedge clk_i) disable iff (!por_n_i)
    MASK_ROM |-> !blocked_o); // R9

endmodule

bind cfgword_boot cfgword_checker #(
  .ADDR_W     (ADDR_W),
  .WORD_BYTES (WORD_BYTES),
  .BASE_ADDR  (BASE_ADDR),
  .MASK_ROM   (MASK_ROM)
) u_chk (
  .clk_i        (clk_i),
  .rst_n_i      (rst_n_i),
  .por_n_i      (por_n_i),
  .test2_i      (test2_i),
  .rd_req_o     (rd_req_o),
  .rd_src_o     (rd_src_o),
  .rd_addr_o    (rd_addr_o),
  .rd_ack_i     (rd_ack_i),
  .lock_wr_i    (lock_wr_i),
  .lock_wdata_i (lock_wdata_i),
  .lock_o       (lock_o),
  .blocked_o    (blocked_o),
  .done_o       (done_o)
);

// File: tb/sim_cfgword_boot.sv
module sim_cfgword_boot;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, por_n, test, test2, lock_wr, lock_wdata;
  int   lat = 0;
  int   checks = 0;
  int   errs = 0;

  // instance u0: lock enforced
  logic        req0, ack0 = 1'b0, lock0, blk0, done0;
  logic [1:0]  src0;
  logic [7:0]  addr0, data0 = '0;
  logic [31:0] cw0;
  // instance u1: mask-ROM variant
  logic        req1, ack1 = 1'b0, lock1, blk1, done1;
  logic [1:0]  src1;
  logic [7:0]  addr1, data1 = '0;
  logic [31:0] cw1;

  int nrd0 = 0, nrd1 = 0, aerr0 = 0, aerr1 = 0, cnt0 = 0, cnt1 = 0;
  logic [1:0] last_src0 = '0, last_src1 = '0;

  cfgword_boot u0 (
    .clk_i(clk), .rst_n_i(rst_n), .por_n_i(por_n), .test_i(test), .test2_i(test2),
    .rd_req_o(req0), .rd_src_o(src0), .rd_addr_o(addr0), .rd_ack_i(ack0), .rd_data_i(data0),
    .lock_wr_i(lock_wr), .lock_wdata_i(lock_wdata), .lock_o(lock0), .blocked_o(blk0),
    .ctrl_word_o(cw0), .done_o(done0));

  cfgword_boot #(.MASK_ROM(1'b1)) u1 (
    .clk_i(clk), .rst_n_i(rst_n), .por_n_i(por_n), .test_i(test), .test2_i(test2),
    .rd_req_o(req1), .rd_src_o(src1), .rd_addr_o(addr1), .rd_ack_i(ack1), .rd_data_i(data1),
    .lock_wr_i(lock_wr), .lock_wdata_i(lock_wdata), .lock_o(lock1), .blocked_o(blk1),
    .ctrl_word_o(cw1), .done_o(done1));

  function automatic logic [7:0] byte_of(input logic [1:0] s, input logic [7:0] a);
    int v;
    v = (int'(a) * 29) ^ ((int'(s) + 1) * 83) ^ 60;
    return 8'(v);
  endfunction

  function automatic logic [31:0] word_of(input logic [1:0] s);
    return {byte_of(s, 8'h23), byte_of(s, 8'h22), byte_of(s, 8'h21), byte_of(s, 8'h20)};
  endfunction

  // memory models with programmable acknowledge latency
  always @(posedge clk) begin
    if (req0 && !ack0) begin
      if (cnt0 >= lat) begin ack0 <= 1'b1; data0 <= byte_of(src0, addr0); cnt0 <= 0; end
      else cnt0 <= cnt0 + 1;
    end else ack0 <= 1'b0;
    if (req0 && ack0) begin
      if (addr0 != 8'(8'h20 + (nrd0 % 4))) aerr0 <= aerr0 + 1;
      nrd0 <= nrd0 + 1; last_src0 <= src0;
    end
  end

  always @(posedge clk) begin
    if (req1 && !ack1) begin
      if (cnt1 >= lat) begin ack1 <= 1'b1; data1 <= byte_of(src1, addr1); cnt1 <= 0; end
      else cnt1 <= cnt1 + 1;
    end else ack1 <= 1'b0;
    if (req1 && ack1) begin
      if (addr1 != 8'(8'h20 + (nrd1 % 4))) aerr1 <= aerr1 + 1;
      nrd1 <= nrd1 + 1; last_src1 <= src1;
    end
  end

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual %h expected %h", rq, act, exp);
    end
  endtask

  task automatic boot(input bit cold);
    int n;
    @(negedge clk);
    rst_n = 1'b0;
    if (cold) por_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R10 done in reset", 32'(done0), 32'd0);
    chk("R10 req in reset", 32'(req0), 32'd0);
    chk("R10 ctrl word in reset", cw0, 32'd0);
    if (cold) chk("R6 lock set by power-on", 32'(lock0), 32'd1);
    rst_n = 1'b1;
    por_n = 1'b1;
    n = 0;
    while (!(done0 && done1) && n < 300) begin
      if (done0 && req0) chk("R5 request after done", 32'd1, 32'd0);
      @(negedge clk);
      n++;
    end
    chk("R5 done reached", 32'(done0 && done1), 32'd1);
  endtask

  bit blk_exp0 = 1'b0;

  task automatic run_case(input bit cold, input bit unlock, input int pins, input int l);
    logic [1:0] exp_src;
    bit exp_lock, blocked;
    int n0, n1;
    lat = l;
    test  = pins[0];
    test2 = pins[1];
    if (!cold) begin
      @(negedge clk);
      lock_wr = 1'b1; lock_wdata = !unlock;
      @(negedge clk);
      lock_wr = 1'b0;
      chk("R7 lock written", 32'(lock0), 32'(!unlock));
      chk("R7 lock written mask-ROM", 32'(lock1), 32'(!unlock));
    end
    exp_lock = cold ? 1'b1 : !unlock;
    n0 = nrd0; n1 = nrd1;
    boot(cold);
    if (cold) blk_exp0 = 1'b0;
    exp_src = test2 ? 2'd1 : (test ? 2'd2 : 2'd0);
    blocked = (exp_src == 2'd2) && exp_lock;
    if (blocked) blk_exp0 = 1'b1;
    if (blocked) begin
      chk("R8 default word when refused", cw0, 32'h0000_7F5F);
      chk("R8 no reads when refused", 32'(nrd0 - n0), 32'd0);
    end else begin
      chk("R4 assembled word", cw0, word_of(exp_src));
      chk("R3 four reads", 32'(nrd0 - n0), 32'd4);
      if (exp_src == 2'd2) chk("R2 external source", 32'(last_src0), 32'd2);
      else                 chk("R1 internal source", 32'(last_src0), 32'(exp_src));
    end
    chk("R8 sticky refusal bit", 32'(blk0), 32'(blk_exp0));
    chk("R6 lock kept through reset", 32'(lock0), 32'(exp_lock));
    chk("R9 mask-ROM word", cw1, word_of(exp_src));
    chk("R9 mask-ROM reads", 32'(nrd1 - n1), 32'd4);
    chk("R9 mask-ROM never refuses", 32'(blk1), 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errs++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errs);
    $finish;
  end

  initial begin
    rst_n = 1'b0; por_n = 1'b0; test = 1'b0; test2 = 1'b0;
    lock_wr = 1'b0; lock_wdata = 1'b0;
    boot(1'b1);
    for (int l = 0; l < 3; l++)
      for (int p = 0; p < 4; p++) begin
        run_case(1'b1, 1'b0, p, l);
        run_case(1'b0, 1'b1, p, l);
        run_case(1'b0, 1'b0, p, l);
      end

    // R7: a clear attempted while reset is held is ignored
    run_case(1'b1, 1'b0, 1, 0);
    @(negedge clk);
    rst_n = 1'b0; test = 1'b1; test2 = 1'b0;
    lock_wr = 1'b1; lock_wdata = 1'b0;
    repeat (4) @(negedge clk);
    chk("R7 write ignored in reset", 32'(lock0), 32'd1);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    lock_wr = 1'b0;
    repeat (20) @(negedge clk);
    chk("R7 still refused after ignored clear", cw0, 32'h0000_7F5F);
    chk("R8 refusal bit set", 32'(blk0), 32'd1);

    // R6: power-on reset and a clearing write in the same cycle
    @(negedge clk);
    lock_wr = 1'b1; lock_wdata = 1'b0;
    @(negedge clk);
    chk("R7 lock cleared", 32'(lock0), 32'd0);
    por_n = 1'b0;
    @(negedge clk);
    chk("R6 power-on wins over write", 32'(lock0), 32'd1);
    chk("R8 refusal bit cleared by power-on", 32'(blk0), 32'd0);
    lock_wr = 1'b0;
    por_n = 1'b1;
    repeat (20) @(negedge clk);
    chk("R6 lock after power-on", 32'(lock0), 32'd1);
    chk("R3 address order u0", 32'(aerr0), 32'd0);
    chk("R3 address order u1", 32'(aerr1), 32'd0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errs);
    $finish;
  end

endmodule